// File: doc/BRIEF.md
# Manual-Mode Comma Word Aligner

The block takes the unaligned parallel words coming out of a deserializer and finds the word boundary. The input is 10 or 20 bits wide, set by a parameter. Each cycle it joins the incoming word with the word before it. It then tests every bit offset for a programmable 10-bit alignment character or for the bitwise complement of that character. When a match is accepted, the block locks onto that offset. From then on it outputs the realigned words, a pattern-detect flag, a sync-status flag and the number of bits it slipped to reach the boundary. Other logic can use that slip count to compensate for latency.

The align-enable input and the sync-status output behave differently in the two widths. In the 10-bit configuration, enable is a level: while it is high, the aligner can move to a new boundary after three consecutive hits there. While it is low, the boundary stays frozen. In the 20-bit configuration, enable works on its rising edge: each rising edge starts exactly one search, the result is then held, and sync-status stays high as a level until the next rising edge.

Top module: `comma_aligner`

## Requirements
- R1: A match is the configured 10-bit pattern `PAT` or its bitwise complement `~PAT`, and either form locks and flags the boundary the same way.
- R2: After reset release, no boundary is acquired while `align_en_i` is low and has never been raised. `slip_o` stays 0 and `sync_o` stays low even when alignment characters arrive at a nonzero offset.
- R3: With `DATA_W`=10, while `align_en_i` is low the boundary is frozen: `slip_o` does not change, whatever patterns arrive.
- R4: With `DATA_W`=10 and enable high, once a boundary is held, the block moves to a different offset only after three consecutive hits at that offset. The count of hits restarts when a hit occurs at the current boundary or at a third offset.
- R5: With `DATA_W`=20, each rising edge of `align_en_i` starts one search, and the first offset found is held. Later patterns at other offsets do not move it while enable stays high.
- R6: `patdet_o` is high for exactly the cycles whose output word holds the pattern or its complement in its low 10 bits (aligned offset).
- R7: With `DATA_W`=10, `sync_o` is a single-cycle pulse. It fires on the output cycle of the first lock and on the output cycle of each three-hit boundary move.
- R8: With `DATA_W`=20, `sync_o` rises with the output cycle of the lock and stays high until the cycle after the next rising edge of `align_en_i`. A falling edge of enable leaves it high.
- R9: `slip_o` equals the bit offset in use: input bit (k·`DATA_W` + `slip_o` + j) appears at `data_o[j]` (bit 0 is the earliest bit in time). `slip_o` changes only on cycles where `sync_o` is high.
- R10: If several offsets match in the same cycle, the lowest offset is taken.
- R11: The output word built from the current and previous input words appears on `data_o` one clock after that input word, already shifted by the boundary chosen in that same cycle.
- R12: While `rst_ni` is low, `data_o`, `patdet_o`, `sync_o` and `slip_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_en_i | input | 1 | Align enable (level in 10-bit mode, rising edge in 20-bit mode) |
| data_i | input | DATA_W | Unaligned word from the deserializer, bit 0 earliest |
| data_o | output | DATA_W | Realigned word |
| patdet_o | output | 1 | Pattern seen on the aligned boundary this cycle |
| sync_o | output | 1 | Sync status (pulse in 10-bit mode, level in 20-bit mode) |
| slip_o | output | $clog2(DATA_W) | Bits slipped to reach the boundary in use |

## Verification
A wrong boundary register shows on the very next output cycle. `data_o` carries a shifted copy of the expected symbol, and `patdet_o` stays low on a cycle where a comma was sent. A stuck or miscounted hit counter shows as a move after the first or second foreign hit, or no move after the third. That is visible on `slip_o` within one cycle of the deciding comma. A lost edge detector or sync register shows up in 20-bit mode as `sync_o` failing to drop in the cycle after a rising edge, or as the held offset following a later comma. The bench places every comma at a known offset, so each of these faults produces a miscompare at a cycle it can predict.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int SYM_W       = 10;
  localparam int RESYNC_HITS = 3;

  typedef enum logic {
    EN_LEVEL,
    EN_EDGE
  } en_mode_e;

  function automatic en_mode_e mode_for(int width);
    return (width <= SYM_W) ? EN_LEVEL : EN_EDGE;
  endfunction
endpackage

// File: rtl/wa_match.sv
module wa_match #(
  parameter int                       DATA_W = 10,
  parameter logic [wa_pkg::SYM_W-1:0] PAT    = 10'b0011111010
) (
  input  logic [DATA_W+wa_pkg::SYM_W-2:0] win_i,
  output logic [DATA_W-1:0]               hit_o
);
  localparam int SW = wa_pkg::SYM_W;

  for (genvar off = 0; off < DATA_W; off++) begin : g_off
    assign hit_o[off] = (win_i[off +: SW] == PAT) || (win_i[off +: SW] == ~PAT);
  end
endmodule

// File: rtl/wa_lowest.sv
module wa_lowest #(
  parameter int W  = 10,
  parameter int IW = 4
) (
  input  logic [W-1:0]  hit_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IW'(i);
    end
    any_o = |hit_i;
  end
endmodule

// File: rtl/wa_ctrl_level.sv
module wa_ctrl_level #(
  parameter int DATA_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] hit_i,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  low_i,
  output logic [IDX_W-1:0]  bnd_nxt_o,
  output logic [IDX_W-1:0]  bnd_o,
  output logic              sync_o
);
  localparam int               CNT_W = $clog2(wa_pkg::RESYNC_HITS + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(wa_pkg::RESYNC_HITS - 1);

  logic [IDX_W-1:0] bnd_q, cand_q, cand_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             locked_q, locked_n, sync_n;

  always_comb begin
    bnd_nxt_o = bnd_q;
    cand_n    = cand_q;
    cnt_n     = cnt_q;
    locked_n  = locked_q;
    sync_n    = 1'b0;
    if (!en_i) begin
      cnt_n = '0;
    end else if (!locked_q) begin
      if (any_i) begin
        bnd_nxt_o = low_i;
        locked_n  = 1'b1;
        sync_n    = 1'b1;
        cnt_n     = '0;
      end
    end else if (hit_i[bnd_q]) begin
      cnt_n = '0;
    end else if (any_i) begin
      if (cnt_q != '0 && low_i == cand_q) begin
        if (cnt_q == LAST) begin
          bnd_nxt_o = low_i;
          cnt_n     = '0;
          sync_n    = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        cand_n = low_i;
        cnt_n  = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_q    <= '0;
      cand_q   <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
      sync_o   <= 1'b0;
    end else begin
      bnd_q    <= bnd_nxt_o;
      cand_q   <= cand_n;
      cnt_q    <= cnt_n;
      locked_q <= locked_n;
      sync_o   <= sync_n;
    end
  end

  assign bnd_o = bnd_q;
endmodule

// File: rtl/wa_ctrl_edge.sv
module wa_ctrl_edge #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] low_i,
  output logic [IDX_W-1:0] bnd_nxt_o,
  output logic [IDX_W-1:0] bnd_o,
  output logic             sync_o
);
  logic [IDX_W-1:0] bnd_q;
  logic             en_q, srch_q, srch_n, sync_n, rise;

  assign rise = en_i && !en_q;

  always_comb begin
    bnd_nxt_o = bnd_q;
    srch_n    = srch_q || rise;
    sync_n    = rise ? 1'b0 : sync_o;
    if (srch_n && any_i) begin
      bnd_nxt_o = low_i;
      srch_n    = 1'b0;
      sync_n    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_q  <= '0;
      en_q   <= 1'b0;
      srch_q <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      bnd_q  <= bnd_nxt_o;
      en_q   <= en_i;
      srch_q <= srch_n;
      sync_o <= sync_n;
    end
  end

  assign bnd_o = bnd_q;
endmodule

// File: rtl/wa_shift.sv
module wa_shift #(
  parameter int DATA_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*DATA_W-2:0] win_i,
  input  logic [DATA_W-1:0]   hit_i,
  input  logic [IDX_W-1:0]    bnd_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                patdet_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      patdet_o <= 1'b0;
    end else begin
      data_o   <= win_i[bnd_i +: DATA_W];
      patdet_o <= hit_i[bnd_i];
    end
  end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int                       DATA_W = 10,
  parameter logic [wa_pkg::SYM_W-1:0] PAT    = 10'b0011111010
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      align_en_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      patdet_o,
  output logic                      sync_o,
  output logic [$clog2(DATA_W)-1:0] slip_o
);
  import wa_pkg::*;

  localparam int       IDX_W = $clog2(DATA_W);
  localparam int       WIN_W = 2 * DATA_W - 1;
  localparam int       MWN_W = DATA_W + SYM_W - 1;
  localparam en_mode_e MODE  = mode_for(DATA_W);

  logic [DATA_W-1:0] prev_q;
  logic [WIN_W-1:0]  win;
  logic [DATA_W-1:0] hit;
  logic              any;
  logic [IDX_W-1:0]  low, bnd_nxt, bnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= data_i;
  end

  // earlier word in the low half, bit 0 oldest
  assign win = {data_i[DATA_W-2:0], prev_q};

  wa_match #(.DATA_W(DATA_W), .PAT(PAT)) u_match (
    .win_i (win[MWN_W-1:0]),
    .hit_o (hit)
  );

  wa_lowest #(.W(DATA_W), .IW(IDX_W)) u_low (
    .hit_i (hit),
    .any_o (any),
    .idx_o (low)
  );

  if (MODE == EN_LEVEL) begin : g_level
    wa_ctrl_level #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (align_en_i),
      .hit_i     (hit),
      .any_i     (any),
      .low_i     (low),
      .bnd_nxt_o (bnd_nxt),
      .bnd_o     (bnd_q),
      .sync_o    (sync_o)
    );
  end else begin : g_edge
    wa_ctrl_edge #(.IDX_W(IDX_W)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (align_en_i),
      .any_i     (any),
      .low_i     (low),
      .bnd_nxt_o (bnd_nxt),
      .bnd_o     (bnd_q),
      .sync_o    (sync_o)
    );
  end

  wa_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_i    (win),
    .hit_i    (hit),
    .bnd_i    (bnd_nxt),
    .data_o   (data_o),
    .patdet_o (patdet_o)
  );

  assign slip_o = bnd_q;
endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
  parameter int                       DATA_W = 10,
  parameter logic [wa_pkg::SYM_W-1:0] PAT    = 10'b0011111010
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      align_en_i,
  input logic [DATA_W-1:0]         data_o,
  input logic                      patdet_o,
  input logic                      sync_o,
  input logic [$clog2(DATA_W)-1:0] slip_o
);
  a_r6_patdet_word : assert property (@(posedge clk_i) disable iff (!rst_ni)
    patdet_o |-> (data_o[wa_pkg::SYM_W-1:0] == PAT || data_o[wa_pkg::SYM_W-1:0] == ~PAT));

  a_r9_slip_on_sync : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(slip_o) |-> sync_o);

  a_r9_slip_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o < ($clog2(DATA_W))'(DATA_W - 1) || slip_o == ($clog2(DATA_W))'(DATA_W - 1));

  if (DATA_W <= wa_pkg::SYM_W) begin : g_level
    a_r7_sync_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_o |=> !sync_o);
    a_r3_freeze : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !align_en_i |=> $stable(slip_o));
  end else begin : g_edge
    a_r8_sync_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_o && !$rose(align_en_i)) |=> sync_o);
    a_r8_sync_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(align_en_i) && !sync_o) |=> $stable(slip_o) || sync_o);
  end
endmodule

bind comma_aligner comma_aligner_chk #(.DATA_W(DATA_W), .PAT(PAT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .align_en_i (align_en_i),
  .data_o     (data_o),
  .patdet_o   (patdet_o),
  .sync_o     (sync_o),
  .slip_o     (slip_o)
);

// File: tb/comma_aligner_tb_top.sv
`timescale 1ns/1ps
module comma_aligner_tb_top;
  localparam logic [9:0] C  = 10'b0011111010;
  localparam logic [9:0] NC = ~C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en10 = 1'b0, en20 = 1'b0;
  logic [9:0]  d10 = '0, q10;
  logic [19:0] d20 = '0, q20;
  logic        pd10, sy10, pd20, sy20;
  logic [3:0]  sl10;
  logic [4:0]  sl20;

  logic [9:0]  p10 = '0;
  logic [19:0] p20 = '0;
  logic [19:0] r_data;
  logic        r_sync, r_pat;
  logic [4:0]  r_slip;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  comma_aligner #(.DATA_W(10)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .align_en_i(en10), .data_i(d10),
    .data_o(q10), .patdet_o(pd10), .sync_o(sy10), .slip_o(sl10));

  comma_aligner #(.DATA_W(20)) dut20_i (
    .clk_i(clk), .rst_ni(rst_n), .align_en_i(en20), .data_i(d20),
    .data_o(q20), .patdet_o(pd20), .sync_o(sy20), .slip_o(sl20));

  // {slip, complement}
  localparam logic [4:0] VEC [6] = '{
    {4'd0, 1'b0}, {4'd3, 1'b1}, {4'd9, 1'b0},
    {4'd5, 1'b1}, {4'd1, 1'b0}, {4'd7, 1'b1}};

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en10 = 1'b0; en20 = 1'b0; d10 = '0; d20 = '0; p10 = '0; p20 = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic send10(input logic [9:0] sym, input int s);
    d10 = 10'({sym, p10} >> (10 - s));
    p10 = sym;
    step();
  endtask

  task automatic hit10(input logic [9:0] sym, input int s);
    send10(sym, s);
    send10('0, s);
    r_sync = sy10; r_pat = pd10; r_data = 20'(q10); r_slip = 5'(sl10);
    send10('0, s);
  endtask

  task automatic send20(input logic [19:0] sym, input int s);
    d20 = 20'({sym, p20} >> (20 - s));
    p20 = sym;
    step();
  endtask

  task automatic hit20(input logic [9:0] sym, input int s);
    send20({10'h0, sym}, s);
    send20('0, s);
    r_sync = sy20; r_pat = pd20; r_data = q20; r_slip = sl20;
    send20('0, s);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    // R1 R9 R11 R7: acquisition at several offsets and polarities, 10-bit mode
    for (int v = 0; v < 6; v++) begin
      logic [9:0] sym;
      int s;
      s   = int'(VEC[v][4:1]);
      sym = VEC[v][0] ? NC : C;
      do_reset();
      en10 = 1'b1;
      send10('0, s);
      hit10(sym, s);
      chk("R9 slip", 40'(r_slip), 40'(s));
      chk("R1 R11 data", 40'(r_data), 40'(sym));
      chk("R6 patdet", 40'(r_pat), 40'd1);
      chk("R7 sync pulse", 40'(r_sync), 40'd1);
      chk("R7 sync drop", 40'(sy10), 40'd0);
      chk("R6 patdet drop", 40'(pd10), 40'd0);
    end

    // R12 reset state
    rst_n = 1'b0; d10 = 10'h3ff; d20 = 20'hfffff;
    step(); step();
    chk("R12 data10", 40'(q10), 40'd0);
    chk("R12 flags10", 40'({pd10, sy10, sl10}), 40'd0);
    chk("R12 data20", 40'(q20), 40'd0);
    chk("R12 flags20", 40'({pd20, sy20, sl20}), 40'd0);
    do_reset();

    // R2 no search before enable
    for (int i = 0; i < 3; i++) begin
      hit10(C, 4);
      chk("R2 slip10", 40'(r_slip), 40'd0);
      chk("R2 sync10", 40'(r_sync), 40'd0);
    end
    en10 = 1'b1;
    hit10(C, 4);
    chk("R2 lock after enable", 40'(r_slip), 40'd4);

    // R3 freeze while enable low
    en10 = 1'b0;
    for (int i = 0; i < 3; i++) begin
      hit10(C, 7);
      chk("R3 frozen slip", 40'(r_slip), 40'd4);
      chk("R3 no sync", 40'(r_sync), 40'd0);
      chk("R3 no patdet", 40'(r_pat), 40'd0);
    end

    // R4 three hits move the boundary
    en10 = 1'b1;
    hit10(C, 7);
    chk("R4 hit1 hold", 40'({r_sync, r_slip}), 40'd4);
    hit10(C, 7);
    chk("R4 hit2 hold", 40'({r_sync, r_slip}), 40'd4);
    hit10(NC, 7);
    chk("R4 hit3 move", 40'(r_slip), 40'd7);
    chk("R7 sync on move", 40'(r_sync), 40'd1);
    chk("R1 R11 data on move", 40'(r_data), 40'(NC));

    // R4 counter cleared by current-boundary and third-offset hits
    hit10(C, 2); hit10(C, 2);
    hit10(C, 7);
    chk("R6 patdet current", 40'(r_pat), 40'd1);
    chk("R7 no sync on current", 40'(r_sync), 40'd0);
    hit10(C, 2);
    hit10(C, 5);
    hit10(C, 2); hit10(C, 2);
    chk("R4 cleared hold", 40'(r_slip), 40'd7);
    hit10(C, 2);
    chk("R4 move after clear", 40'(r_slip), 40'd2);
    chk("R7 sync after clear", 40'(r_sync), 40'd1);

    // 20-bit mode
    do_reset();
    hit20(C, 6);
    chk("R2 slip20", 40'({r_sync, r_slip}), 40'd0);
    en20 = 1'b1;
    hit20(C, 6);
    chk("R5 lock20", 40'(r_slip), 40'd6);
    chk("R8 sync20 high", 40'(r_sync), 40'd1);
    chk("R11 data20", 40'(r_data), 40'(C));
    hit20(C, 11);
    hit20(C, 11);
    chk("R5 held", 40'(r_slip), 40'd6);
    chk("R8 held sync", 40'(r_sync), 40'd1);
    chk("R6 no patdet off-boundary", 40'(r_pat), 40'd0);
    hit20(NC, 6);
    chk("R6 R1 patdet20", 40'(r_pat), 40'd1);
    chk("R1 data20 complement", 40'(r_data), 40'({10'h0, NC}));
    en20 = 1'b0;
    hit20(C, 11);
    chk("R8 sync after fall", 40'({r_sync, r_slip}), 40'({1'b1, 5'd6}));
    en20 = 1'b1;
    send20('0, 11);
    chk("R8 sync cleared", 40'(sy20), 40'd0);
    hit20(C, 11);
    chk("R5 new search", 40'(r_slip), 40'd11);
    chk("R8 sync again", 40'(r_sync), 40'd1);

    // R10 lowest offset wins
    begin
      logic [39:0] w;
      w = (40'(C) << 2) | (40'(C) << 15);
      en20 = 1'b0; send20('0, 0);
      en20 = 1'b1; send20('0, 0);
      d20 = w[19:0]; step();
      d20 = w[39:20]; step();
      chk("R10 lowest slip", 40'(sl20), 40'd2);
      chk("R10 data", 40'(q20), 40'(w[21:2]));
      chk("R10 patdet", 40'(pd20), 40'd1);
    end

    finish_run();
  end
endmodule